// File: doc/BRIEF.md
# Receive Descriptor Ring Walker

This block runs the receive half of a network controller's buffer ring in system memory. Software places a ring of two-word descriptors in memory. Word 0 of each descriptor names a 128-byte buffer and carries two flags: an ownership flag and a wrap marker. Software loads the ring's base address while receive is off and then turns receive on. From then on the block walks the ring by itself. When a frame starts, it reads the current descriptor through a single-cycle memory port. If the hardware owns the entry, it stores the frame bytes into that buffer, one 32-bit word at a time with byte enables. When the buffer fills or the frame ends, it writes both descriptor words back and moves to the next entry.

Frame bytes arrive as a byte stream with a valid flag and an end-of-frame flag. The block answers with a ready flag, which stays low while a descriptor is read or written back. A frame longer than one buffer continues into the following descriptors. The block returns to the ring base either on a set wrap marker or after the last entry of a fixed-size ring. If a descriptor is still owned by software, the block raises a sticky status flag, discards the rest of that frame and retries the same entry when the next frame starts.

Top module: `rxring_walker`

## Requirements
- R1: After reset, the outputs hold these values: rx_ready 0, mem_req 0, cur_idx 0, bna_status 0 and lpbk_mode 0.
- R2: cfg_base (bits 2:0 forced to zero) and cfg_lpbk are taken on a cycle with cfg_we high only while rx_enable is low. A write made while rx_enable is high has no effect, either on lpbk_mode or on the ring base used later.
- R3: Entry i is read from base + 8*i. In word 0, bit 0 is the ownership flag, where 0 means the hardware may use the entry. Word 0 bits 31:2 give the word-aligned buffer address. Frame byte n of that buffer is stored at buffer + n, with byte lane n mod 4 of a little-endian word.
- R4: A buffer holds exactly 128 bytes. Byte 129 of a frame, and every later byte, goes into the buffers of the following entries.
- R5: When an entry is finished, word 0 is written back with bit 0 set to 1 and its address and wrap bit kept. Word 1 is then written with bit 14 set on the first buffer of a frame and bit 15 set on the last buffer. On the last buffer, bits 11:0 carry the frame length in bytes; on any other buffer they are 0. The write of word 0 comes one cycle after the entry's final byte is accepted, and the write of word 1 comes one cycle after that.
- R6: When bit 1 (the wrap marker) of the finished entry's word 0 is set, the next entry is index 0.
- R7: Without a wrap marker, the entry after index 1023 is index 0.
- R8: A fetched word 0 with bit 0 equal to 1 sets bna_status, which then stays set. The rest of that frame is accepted and discarded with no memory write, cur_idx does not change, and the next frame uses the same entry.
- R9: While rx_enable is low, cur_idx is 0, so receive restarts at the ring base. bna_status is cleared in the cycle receive is turned back on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Receive on |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_base | input | 32 | Ring base address to load |
| cfg_lpbk | input | 1 | Loop-back setting to load |
| rx_valid | input | 1 | Frame byte present |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_ready | output | 1 | Byte is taken at this edge when valid |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the request |
| cur_idx | output | 10 | Current ring entry index |
| bna_status | output | 1 | Sticky flag: a descriptor was not available |
| lpbk_mode | output | 1 | Loop-back setting in force |

## Verification
Each byte accepted at a clock edge reaches memory at that same edge. For the entry that byte finishes, word 0 lands one edge later and word 1 two edges later, and cur_idx changes on that second edge. The bench therefore waits three falling edges after the last byte is accepted before it reads memory and cur_idx. A descriptor still owned by software is seen in the cycle after the frame's first byte appears, and bna_status rises on the next edge. The bench checks that flag, and the untouched buffer, only after the whole frame has been consumed. The expected descriptor words, buffer contents and ring position all come from a model of the ring that the bench keeps for itself.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int OWN_BIT  = 0;
  localparam int WRAP_BIT = 1;
  localparam int SOF_BIT  = 14;
  localparam int EOF_BIT  = 15;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_IDLE,
    ST_FETCH,
    ST_DATA,
    ST_WB0,
    ST_WB1,
    ST_DROP
  } rx_state_e;

  // Word 0 handed back: address and wrap kept, ownership given to software
  function automatic logic [31:0] close_word0(input logic [31:0] buf_addr,
                                              input logic        wrap);
    logic [31:0] w;
    w           = {buf_addr[31:2], 2'b00};
    w[WRAP_BIT] = wrap;
    w[OWN_BIT]  = 1'b1;
    return w;
  endfunction

  // Byte enables for a word closed at the given lane
  function automatic logic [3:0] lane_mask(input logic [1:0] lane);
    case (lane)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      2'd2:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  // Held lower lanes plus the incoming byte in its own lane
  function automatic logic [31:0] merge_lanes(input logic [23:0] hold,
                                              input logic [7:0]  b,
                                              input logic [1:0]  lane);
    case (lane)
      2'd0:    return {24'h0, b};
      2'd1:    return {16'h0, b, hold[7:0]};
      2'd2:    return {8'h0, b, hold[15:0]};
      default: return {b, hold};
    endcase
  endfunction

endpackage

// File: rtl/rxr_cfg.sv
module rxr_cfg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_enable,
  input  logic        cfg_we,
  input  logic [31:0] cfg_base,
  input  logic        cfg_lpbk,
  output logic [31:0] base_q,
  output logic        lpbk_q,
  output logic        en_rise
);

  logic en_d;
  logic take_cfg;

  assign take_cfg = cfg_we & ~rx_enable;
  assign en_rise  = rx_enable & ~en_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      lpbk_q <= 1'b0;
      en_d   <= 1'b0;
    end else begin
      en_d <= rx_enable;
      if (take_cfg) begin
        base_q <= cfg_base & ~32'h7;
        lpbk_q <= cfg_lpbk;
      end
    end
  end

endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int RING_MAX = 1024,
  parameter int IDX_W    = $clog2(RING_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_enable,
  input  logic [31:0]      base,
  input  logic             advance,
  input  logic             wrap_seen,
  output logic [IDX_W-1:0] idx,
  output logic [31:0]      desc_addr,
  output logic             ev_ring_home
);

  localparam int PAD_W = 32 - IDX_W - 3;

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i,
                                                input logic             w);
    if (w || i == IDX_W'(RING_MAX - 1)) return '0;
    return i + 1'b1;
  endfunction

  logic [IDX_W-1:0] idx_nx;

  assign idx_nx       = step_idx(idx, wrap_seen);
  assign ev_ring_home = advance & (idx_nx == '0);
  assign desc_addr    = base + {{PAD_W{1'b0}}, idx, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n)          idx <= '0;
    else if (!rx_enable) idx <= '0;
    else if (advance)    idx <= idx_nx;
  end

endmodule

// File: rtl/rxr_packer.sv
module rxr_packer #(
  parameter int BUF_BYTES = 128,
  parameter int BC_W      = $clog2(BUF_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic [7:0]      rx_data,
  input  logic            rx_last,
  input  logic [BC_W-1:0] bc,
  input  logic [31:0]     buf_addr,
  output logic            wr_req,
  output logic [31:0]     wr_addr,
  output logic [31:0]     wr_data,
  output logic [3:0]      wr_be
);

  import rxr_pkg::*;

  localparam int PAD_W = 32 - BC_W;

  logic [1:0]  lane;
  logic [23:0] hold;

  assign lane    = bc[1:0];
  assign wr_req  = accept & ((lane == 2'd3) | rx_last);
  assign wr_addr = buf_addr + {{PAD_W{1'b0}}, bc[BC_W-1:2], 2'b00};
  assign wr_data = merge_lanes(hold, rx_data, lane);
  assign wr_be   = lane_mask(lane);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
    end else if (accept) begin
      case (lane)
        2'd0:    hold[7:0]   <= rx_data;
        2'd1:    hold[15:8]  <= rx_data;
        2'd2:    hold[23:16] <= rx_data;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rxr_engine.sv
module rxr_engine #(
  parameter int BUF_BYTES = 128,
  parameter int BC_W      = $clog2(BUF_BYTES),
  parameter int LEN_W     = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_enable,
  input  logic                en_rise,
  input  logic                rx_valid,
  input  logic                rx_last,
  input  logic [31:0]         mem_rdata,
  output rxr_pkg::rx_state_e  st,
  output logic                rx_ready,
  output logic                accept,
  output logic [BC_W-1:0]     bc,
  output logic [31:0]         buf_addr,
  output logic                wrap_q,
  output logic                desc_rd,
  output logic                desc_wr,
  output logic                desc_hi,
  output logic [31:0]         desc_wdata,
  output logic                advance,
  output logic                bna_q,
  output logic                ev_bna,
  output logic                ev_buf_full,
  output logic                ev_frame_end
);

  import rxr_pkg::*;

  function automatic logic [31:0] close_word1(input logic             sof,
                                              input logic             eof,
                                              input logic [LEN_W-1:0] len);
    logic [31:0] w;
    w          = '0;
    w[SOF_BIT] = sof;
    w[EOF_BIT] = eof;
    if (eof) w[LEN_W-1:0] = len;
    return w;
  endfunction

  logic [LEN_W-1:0] flen;
  logic             sof_q;
  logic             eof_q;
  logic             buf_top;

  assign buf_top      = (bc == BC_W'(BUF_BYTES - 1));
  assign rx_ready     = (st == ST_DATA) | (st == ST_DROP);
  assign accept       = (st == ST_DATA) & rx_valid;
  assign desc_rd      = (st == ST_FETCH);
  assign desc_wr      = (st == ST_WB0) | (st == ST_WB1);
  assign desc_hi      = (st == ST_WB1);
  assign desc_wdata   = desc_hi ? close_word1(sof_q, eof_q, flen)
                                : close_word0(buf_addr, wrap_q);
  assign advance      = (st == ST_WB1);
  assign ev_bna       = desc_rd & mem_rdata[OWN_BIT];
  assign ev_buf_full  = accept & ~rx_last & buf_top;
  assign ev_frame_end = accept & rx_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_OFF;
      bc       <= '0;
      flen     <= '0;
      buf_addr <= '0;
      wrap_q   <= 1'b0;
      sof_q    <= 1'b0;
      eof_q    <= 1'b0;
      bna_q    <= 1'b0;
    end else begin
      if (en_rise)     bna_q <= 1'b0;
      else if (ev_bna) bna_q <= 1'b1;

      if (!rx_enable) begin
        st <= ST_OFF;
      end else begin
        case (st)
          ST_OFF: st <= ST_IDLE;
          ST_IDLE: begin
            if (rx_valid) begin
              st    <= ST_FETCH;
              sof_q <= 1'b1;
              flen  <= '0;
            end
          end
          ST_FETCH: begin
            if (mem_rdata[OWN_BIT]) begin
              st <= ST_DROP;
            end else begin
              buf_addr <= {mem_rdata[31:2], 2'b00};
              wrap_q   <= mem_rdata[WRAP_BIT];
              bc       <= '0;
              st       <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (rx_valid) begin
              bc   <= bc + 1'b1;
              flen <= flen + 1'b1;
              if (rx_last) begin
                eof_q <= 1'b1;
                st    <= ST_WB0;
              end else if (buf_top) begin
                eof_q <= 1'b0;
                st    <= ST_WB0;
              end
            end
          end
          ST_WB0: st <= ST_WB1;
          ST_WB1: begin
            sof_q <= 1'b0;
            st    <= eof_q ? ST_IDLE : ST_FETCH;
          end
          ST_DROP: begin
            if (rx_valid && rx_last) st <= ST_IDLE;
          end
          default: st <= ST_OFF;
        endcase
      end
    end
  end

endmodule

// File: rtl/rxring_walker.sv
module rxring_walker #(
  parameter int RING_MAX  = 1024,
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 12,
  parameter int IDX_W     = $clog2(RING_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_enable,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_base,
  input  logic             cfg_lpbk,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  output logic             rx_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic [IDX_W-1:0] cur_idx,
  output logic             bna_status,
  output logic             lpbk_mode
);

  localparam int BC_W = $clog2(BUF_BYTES);

  // Named internal events, brought out for the bound checker
  logic [31:0]        base_q;
  logic               en_rise;
  rxr_pkg::rx_state_e st;
  logic               accept;
  logic [BC_W-1:0]    bc;
  logic [31:0]        buf_addr;
  logic               wrap_q;
  logic               desc_rd;
  logic               desc_wr;
  logic               desc_hi;
  logic [31:0]        desc_wdata;
  logic [31:0]        desc_addr;
  logic               advance;
  logic               ev_bna;
  logic               ev_buf_full;
  logic               ev_frame_end;
  logic               ev_ring_home;
  logic               pk_req;
  logic [31:0]        pk_addr;
  logic [31:0]        pk_data;
  logic [3:0]         pk_be;
  logic               desc_acc;

  rxr_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_enable (rx_enable),
    .cfg_we    (cfg_we),
    .cfg_base  (cfg_base),
    .cfg_lpbk  (cfg_lpbk),
    .base_q    (base_q),
    .lpbk_q    (lpbk_mode),
    .en_rise   (en_rise)
  );

  rxr_ring_ptr #(.RING_MAX(RING_MAX), .IDX_W(IDX_W)) u_ptr (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_enable    (rx_enable),
    .base         (base_q),
    .advance      (advance),
    .wrap_seen    (wrap_q),
    .idx          (cur_idx),
    .desc_addr    (desc_addr),
    .ev_ring_home (ev_ring_home)
  );

  rxr_engine #(.BUF_BYTES(BUF_BYTES), .BC_W(BC_W), .LEN_W(LEN_W)) u_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_enable    (rx_enable),
    .en_rise      (en_rise),
    .rx_valid     (rx_valid),
    .rx_last      (rx_last),
    .mem_rdata    (mem_rdata),
    .st           (st),
    .rx_ready     (rx_ready),
    .accept       (accept),
    .bc           (bc),
    .buf_addr     (buf_addr),
    .wrap_q       (wrap_q),
    .desc_rd      (desc_rd),
    .desc_wr      (desc_wr),
    .desc_hi      (desc_hi),
    .desc_wdata   (desc_wdata),
    .advance      (advance),
    .bna_q        (bna_status),
    .ev_bna       (ev_bna),
    .ev_buf_full  (ev_buf_full),
    .ev_frame_end (ev_frame_end)
  );

  rxr_packer #(.BUF_BYTES(BUF_BYTES), .BC_W(BC_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .rx_data  (rx_data),
    .rx_last  (rx_last),
    .bc       (bc),
    .buf_addr (buf_addr),
    .wr_req   (pk_req),
    .wr_addr  (pk_addr),
    .wr_data  (pk_data),
    .wr_be    (pk_be)
  );

  // One memory port: descriptor traffic and buffer writes never overlap
  assign desc_acc = desc_rd | desc_wr;

  always_comb begin
    mem_req   = desc_acc | pk_req;
    mem_we    = desc_wr | pk_req;
    mem_addr  = pk_addr;
    mem_be    = pk_be;
    mem_wdata = pk_data;
    if (desc_acc) begin
      mem_addr  = desc_addr + (desc_hi ? 32'd4 : 32'd0);
      mem_be    = 4'hF;
      mem_wdata = desc_wdata;
    end
  end

endmodule

// File: rtl/rxr_walker_chk.sv
module rxr_walker_chk #(
  parameter int RING_MAX  = 1024,
  parameter int BUF_BYTES = 128,
  parameter int IDX_W     = $clog2(RING_MAX),
  parameter int BC_W      = $clog2(BUF_BYTES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rx_enable,
  input logic               rx_valid,
  input logic               rx_last,
  input logic               mem_req,
  input logic               mem_we,
  input logic [31:0]        mem_addr,
  input logic [31:0]        mem_wdata,
  input logic [IDX_W-1:0]   cur_idx,
  input logic               bna_status,
  input logic               lpbk_mode,
  input logic [31:0]        base_q,
  input logic               en_rise,
  input rxr_pkg::rx_state_e st,
  input logic [BC_W-1:0]    bc,
  input logic [31:0]        buf_addr,
  input logic               wrap_q,
  input logic               advance
);

  import rxr_pkg::*;

  a_r2_base_locked: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enable |=> $stable(base_q));

  a_r2_lpbk_locked: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enable |=> $stable(lpbk_mode));

  a_r3_write_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && st == ST_DATA) |-> ((mem_addr - buf_addr) < 32'(BUF_BYTES)));

  a_r4_full_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_enable && st == ST_DATA && rx_valid && !rx_last && bc == BC_W'(BUF_BYTES - 1))
      |=> (st == ST_WB0));

  a_r5_word1_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_enable && st == ST_WB0) |=> (st == ST_WB1));

  a_r5_owner_back: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WB0) |-> (mem_req && mem_we && mem_wdata[OWN_BIT]));

  a_r6_wrap_home: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_enable && advance && wrap_q) |=> (cur_idx == '0));

  a_r7_limit_home: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && cur_idx == IDX_W'(RING_MAX - 1)) |=> (cur_idx == '0));

  a_r8_bna_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (bna_status && !en_rise) |=> bna_status);

  a_r8_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DROP) |-> !mem_req);

  a_r9_idx_home: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> (cur_idx == '0));

endmodule

bind rxring_walker rxr_walker_chk #(.RING_MAX(RING_MAX), .BUF_BYTES(BUF_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_enable  (rx_enable),
  .rx_valid   (rx_valid),
  .rx_last    (rx_last),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .cur_idx    (cur_idx),
  .bna_status (bna_status),
  .lpbk_mode  (lpbk_mode),
  .base_q     (base_q),
  .en_rise    (en_rise),
  .st         (st),
  .bc         (bc),
  .buf_addr   (buf_addr),
  .wrap_q     (wrap_q),
  .advance    (advance)
);

// File: tb/tb_rxring_walker.sv
module tb_rxring_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_enable = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_base = '0;
  logic        cfg_lpbk = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_last = 1'b0;
  logic        rx_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic [9:0]  cur_idx;
  logic        bna_status, lpbk_mode;

  logic [31:0] mem [0:4095];
  logic        bd_we = 1'b0;
  logic [31:0] bd_addr = '0;
  logic [31:0] bd_data = '0;

  int tests = 0;
  int fails = 0;
  int exp_idx = 0;
  int rbase, rn, rbuf0;
  bit rsame, rwrap;

  always #4 clk = ~clk;

  rxring_walker dut (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .cfg_we(cfg_we),
    .cfg_base(cfg_base), .cfg_lpbk(cfg_lpbk), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cur_idx(cur_idx),
    .bna_status(bna_status), .lpbk_mode(lpbk_mode)
  );

  assign mem_rdata = mem[mem_addr[13:2]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4096; k++) mem[k] <= '0;
    end else if (bd_we) begin
      mem[bd_addr[13:2]] <= bd_data;
    end else if (mem_req && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[13:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  function automatic logic [7:0] bval(input int fs, input int i);
    return 8'((fs * 13 + i * 7 + (i >> 3)) ^ 8'h5A);
  endfunction

  function automatic logic [31:0] rd_word(input int a);
    return mem[(a >> 2) & 4095];
  endfunction

  function automatic logic [7:0] rd_byte(input int a);
    logic [31:0] w;
    w = mem[(a >> 2) & 4095];
    return w[8 * (a & 3) +: 8];
  endfunction

  function automatic int buf_at(input int e);
    return rsame ? rbuf0 : rbuf0 + 128 * e;
  endfunction

  function automatic bit wrap_of(input int e);
    return rwrap && (e == rn - 1);
  endfunction

  function automatic int next_e(input int e);
    return (wrap_of(e) || e == 1023) ? 0 : e + 1;
  endfunction

  function automatic logic [31:0] exp_w0(input int e);
    return 32'(buf_at(e)) | (32'(wrap_of(e)) << 1) | 32'd1;
  endfunction

  function automatic logic [31:0] exp_w1(input bit sof, input bit eof, input int len);
    return (32'(eof) << 15) | (32'(sof) << 14) | (eof ? 32'(len & 12'hFFF) : 32'd0);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic bd_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_addr = 32'(a); bd_data = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic cfg_write(input logic [31:0] b, input logic l);
    @(negedge clk);
    cfg_we = 1'b1; cfg_base = b; cfg_lpbk = l;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup_ring(input int base, input int n, input int buf0,
                            input bit same, input bit wrap);
    rbase = base; rn = n; rbuf0 = buf0; rsame = same; rwrap = wrap;
    for (int e = 0; e < n; e++) begin
      bd_write(base + 8 * e, exp_w0(e) & ~32'd1);
      bd_write(base + 8 * e + 4, 32'd0);
    end
  endtask

  task automatic send_frame(input int len, input int fs);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = bval(fs, i); rx_last = (i == len - 1);
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic run_frame(input int len, input int fs, input bit rearm, input string itag);
    int e;
    int nb;
    e  = exp_idx;
    nb = (len + 127) / 128;
    send_frame(len, fs);
    repeat (3) @(negedge clk);
    for (int j = 0; j < nb; j++) begin
      bit last;
      int bad;
      int rem;
      int da;
      last = (j == nb - 1);
      da   = rbase + 8 * e;
      rem  = last ? len - 128 * j : 128;
      bad  = 0;
      chk(rd_word(da) == exp_w0(e), "R5", "word0 handed back", rd_word(da), exp_w0(e));
      chk(rd_word(da + 4) == exp_w1(j == 0, last, len), "R5", "word1 flags/length",
          rd_word(da + 4), exp_w1(j == 0, last, len));
      for (int k = 0; k < rem; k++)
        if (rd_byte(buf_at(e) + k) != bval(fs, 128 * j + k)) bad++;
      chk(bad == 0, (nb > 1) ? "R4" : "R3", "buffer bytes wrong", 32'(bad), 32'd0);
      if (rearm) begin
        bd_write(da, exp_w0(e) & ~32'd1);
        bd_write(da + 4, 32'd0);
      end
      e = next_e(e);
    end
    exp_idx = e;
    chk(cur_idx == 10'(exp_idx), itag, "cur_idx after frame", 32'(cur_idx), 32'(exp_idx));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed_dummy;
    int len;
    int marker_buf;
    seed_dummy = $urandom(32'd2024);

    // R1: reset state
    repeat (5) @(negedge clk);
    chk(rx_ready == 1'b0, "R1", "rx_ready in reset", 32'(rx_ready), 32'd0);
    chk(mem_req == 1'b0, "R1", "mem_req in reset", 32'(mem_req), 32'd0);
    chk(cur_idx == 10'd0, "R1", "cur_idx in reset", 32'(cur_idx), 32'd0);
    chk(bna_status == 1'b0, "R1", "bna in reset", 32'(bna_status), 32'd0);
    chk(lpbk_mode == 1'b0, "R1", "lpbk in reset", 32'(lpbk_mode), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: configuration only while disabled
    setup_ring(32'h3000, 6, 32'h3100, 1'b0, 1'b1);
    cfg_write(32'h3000, 1'b1);
    chk(lpbk_mode == 1'b1, "R2", "lpbk loaded while off", 32'(lpbk_mode), 32'd1);
    @(negedge clk); rx_enable = 1'b1;
    @(negedge clk);
    cfg_write(32'h0000, 1'b0);
    chk(lpbk_mode == 1'b1, "R2", "lpbk write while on ignored", 32'(lpbk_mode), 32'd1);
    exp_idx = 0;

    // Directed lengths: base must still be the first ring (R2)
    run_frame(1, 11, 1'b1, "R2");
    run_frame(4, 12, 1'b1, "R3");
    run_frame(5, 13, 1'b1, "R3");
    run_frame(128, 14, 1'b1, "R4");
    run_frame(129, 15, 1'b1, "R6");

    // Random frames over the wrapping ring
    for (int f = 0; f < 25; f++) begin
      len = 1 + int'($urandom % 400);
      run_frame(len, int'($urandom % 1000), 1'b1, "R6");
    end

    // R8: descriptor still owned by software
    marker_buf = buf_at(exp_idx);
    bd_write(rbase + 8 * exp_idx, exp_w0(exp_idx));
    bd_write(marker_buf, 32'hA5A5_A5A5);
    send_frame(40, 77);
    repeat (3) @(negedge clk);
    chk(bna_status == 1'b1, "R8", "bna set", 32'(bna_status), 32'd1);
    chk(cur_idx == 10'(exp_idx), "R8", "idx held", 32'(cur_idx), 32'(exp_idx));
    chk(rd_word(marker_buf) == 32'hA5A5_A5A5, "R8", "buffer untouched",
        rd_word(marker_buf), 32'hA5A5_A5A5);
    chk(rd_word(rbase + 8 * exp_idx + 4) == 32'd0, "R8", "word1 untouched",
        rd_word(rbase + 8 * exp_idx + 4), 32'd0);
    bd_write(rbase + 8 * exp_idx, exp_w0(exp_idx) & ~32'd1);
    run_frame(10, 78, 1'b1, "R8");
    chk(bna_status == 1'b1, "R8", "bna sticky", 32'(bna_status), 32'd1);

    // R9: disable and re-enable
    @(negedge clk); rx_enable = 1'b0;
    @(negedge clk);
    chk(cur_idx == 10'd0, "R9", "idx home while off", 32'(cur_idx), 32'd0);
    rx_enable = 1'b1;
    @(negedge clk);
    chk(bna_status == 1'b0, "R9", "bna cleared on enable", 32'(bna_status), 32'd0);
    exp_idx = 0;
    run_frame(7, 79, 1'b1, "R9");

    // R7: ring of 1024 entries without a wrap marker
    @(negedge clk); rx_enable = 1'b0;
    cfg_write(32'h0000, 1'b0);
    chk(lpbk_mode == 1'b0, "R2", "lpbk reloaded while off", 32'(lpbk_mode), 32'd0);
    setup_ring(32'h0000, 1024, 32'h2000, 1'b1, 1'b0);
    @(negedge clk); rx_enable = 1'b1;
    @(negedge clk);
    exp_idx = 0;
    for (int f = 0; f < 1024; f++) run_frame(1, f, 1'b0, "R7");
    chk(cur_idx == 10'd0, "R7", "idx back to 0 after 1024", 32'(cur_idx), 32'd0);
    bd_write(32'h0000, exp_w0(0) & ~32'd1);
    bd_write(32'h0004, 32'd0);
    run_frame(1, 500, 1'b0, "R7");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule